// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects interrupt requests for a group of processors that share one register-mapped controller. Fifteen primary sources, numbered 1 to 15, are held in a pending word. A pending bit is set by a rising edge on its input line or by a software force write. It stays set until a clear write or a processor acknowledge removes it. Each processor owns a mask word. For each processor, the block drives a 4-bit level: the highest-numbered source that is both pending and enabled for it. The processor turns that level into a trap code by adding 0x10, which gives codes 0x11 to 0x1F.

Sources 16 to 31 are extended sources. They share one primary line, chosen by a parameter, as a carrier. When a processor acknowledges the carrier level, the controller retires the highest extended source that processor has enabled. It also stores that source's number in the processor's own identification word, so the handler can find out which extended source it is serving. A status word gives the number of processors and a broadcast-capability flag.

Software reaches every word over a simple single-cycle register bus. Writes take effect at the clock edge where select and write are both high. Read data is combinational while select is high and write is low.

Top module: `mpirq_ctrl`

## Requirements
- R1: After reset the pending word, every mask word and every identification word read zero, and every processor level is 0.
- R2: A write to offset 0x04 (the force action) sets pending bit n for each bit n in 1..31 written as 1. Bit 0 is never set. Reading offset 0x04 returns the pending word, with bit n equal to 1 while source n is pending.
- R3: A write to offset 0x08 clears pending bit n for each bit written as 1. Bits written as 0 leave their pending bit unchanged.
- R4: A low-to-high change of input line n (1..31), seen at a clock edge, sets pending bit n at that edge. A line that stays high does not set the bit again after it has been cleared.
- R5: Processor c has a mask word at offset 0x40+4c. It is written and read back at that offset, and bit n set to 1 enables source n for processor c.
- R6: The level of processor c is the highest n in 1..15 whose effective pending bit is set and whose mask bit is 1 for c. The level is 0 when no such n exists.
- R7: Line EXT_LINE is effectively pending for processor c when pending bit EXT_LINE is set, or when any extended source k in 16..31 is pending with mask bit k of c set. In both cases the line still needs mask bit EXT_LINE of c.
- R8: An acknowledge by processor c of level L (nonzero) clears pending bit L at that clock edge. A set of the same bit in the same cycle, by edge or force, takes precedence.
- R9: When processor c acknowledges level EXT_LINE, the highest pending extended source k that c has enabled is also cleared. The identification word of c, at offset 0xC0+4c, becomes k (5 bits, so bit 4 is 1). If there is no such k, it becomes 0. Any other acknowledge leaves the word unchanged.
- R10: Offset 0x10 reads NCPU-1 in bits 31:28 and the broadcast-capability parameter in bit 27. All other bits read 0.
- R11: Reads of offset 0x00, of unaligned addresses, of mask or identification slots at index NCPU or above, and of any other unmapped offset return zero. Writes there change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_in | input | 32 | Interrupt lines, bit n = source n, bit 0 unused |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_level | input | 4*NCPU | Acknowledged level, 4 bits per processor |
| irq_level | output | 4*NCPU | Current level, 4 bits per processor |

## Verification
A pending or mask bit that is set wrongly shows up on the same processor's level output one clock edge after the write or input edge that caused it. It also shows up in a read of the pending word. A fault in the extended path shows up differently. The carrier level may look correct until an acknowledge retires the wrong extended source. So the identification word and the remaining pending bits are read right after each carrier acknowledge, and the level of every other processor is checked at the same point.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;

   localparam int WORD_W = 32;
   localparam int LVL_W  = 4;
   localparam int EID_W  = 5;
   localparam int PRIM_N = 16;

   localparam logic [7:0] OFS_PEND  = 8'h04;
   localparam logic [7:0] OFS_CLEAR = 8'h08;
   localparam logic [7:0] OFS_STAT  = 8'h10;
   localparam logic [1:0] REG_MASK  = 2'b01;
   localparam logic [1:0] REG_EID   = 2'b11;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      logic             found;
      logic [EID_W-1:0] idx;
   } hit_t;

   // highest set bit of a word
   function automatic hit_t top_hit(input word_t v);
      hit_t h;
      h = '0;
      for (int i = 0; i < WORD_W; i++) begin
         if (v[i]) begin
            h.found = 1'b1;
            h.idx   = EID_W'(i);
         end
      end
      return h;
   endfunction

endpackage

// File: rtl/mpirq_pend.sv
module mpirq_pend
   import mpirq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  word_t irq_in,
   input  logic  force_we,
   input  logic  clear_we,
   input  word_t wdata,
   input  word_t ack_clr,
   output word_t pend_o
);

   word_t line_q;
   word_t pend_q;
   word_t set_v;
   word_t clr_v;

   always_comb begin
      set_v    = (irq_in & ~line_q) | (force_we ? wdata : '0);
      set_v[0] = 1'b0;
      clr_v    = (clear_we ? wdata : '0) | ack_clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         pend_q <= '0;
      end else begin
         line_q <= irq_in;
         pend_q <= (pend_q & ~clr_v) | set_v;
      end
   end

   assign pend_o = pend_q;

   p_bit0_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[0] == 1'b0);

   p_set_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(set_v)) == $past(set_v)));

   p_clr_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(clr_v & ~set_v)) == '0));

endmodule

// File: rtl/mpirq_cpu.sv
module mpirq_cpu
   import mpirq_pkg::*;
#(
   parameter int EXT_LINE = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we,
   input  word_t            wdata,
   input  word_t            pend,
   input  logic             ack_valid,
   input  logic [LVL_W-1:0] ack_level,
   output logic [LVL_W-1:0] level_o,
   output word_t            mask_o,
   output logic [EID_W-1:0] eid_o,
   output word_t            ack_clr_o
);

   localparam logic [LVL_W-1:0] EXT_LVL = LVL_W'(EXT_LINE);

   word_t            mask_q;
   logic [EID_W-1:0] eid_q;
   word_t            ext_hit;
   logic             ext_any;
   word_t            eff;
   hit_t             prim;
   hit_t             ext;
   logic             ack_ext;

   always_comb begin
      ext_hit          = pend & mask_q;
      ext_hit[15:0]    = '0;
      ext_any          = |ext_hit;
      ext              = top_hit(ext_hit);
      eff              = '0;
      eff[15:0]        = pend[15:0];
      eff[EXT_LINE]    = pend[EXT_LINE] | ext_any;
      eff              = eff & mask_q;
      eff[0]           = 1'b0;
      prim             = top_hit(eff);
      level_o          = prim.found ? prim.idx[LVL_W-1:0] : '0;
      ack_ext          = ack_valid && (ack_level == EXT_LVL);
      ack_clr_o        = '0;
      if (ack_valid && ack_level != '0)
         ack_clr_o[ack_level] = 1'b1;
      if (ack_ext && ext_any)
         ack_clr_o[ext.idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         eid_q  <= '0;
      end else begin
         if (mask_we)
            mask_q <= wdata;
         if (ack_ext)
            eid_q <= ext_any ? ext.idx : '0;
      end
   end

   assign mask_o = mask_q;
   assign eid_o  = eid_q;

   p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask_q == $past(wdata)));

   p_level_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != '0) |-> mask_q[level_o]);

   p_level_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != '0 && level_o != EXT_LVL) |-> pend[level_o]);

   p_eid_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_ext |=> $stable(eid_q));

   p_eid_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eid_q != '0) |-> eid_q[EID_W-1]);

endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
   import mpirq_pkg::*;
#(
   parameter int   NCPU      = 4,
   parameter int   EXT_LINE  = 12,
   parameter logic HAS_BCAST = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [7:0]            bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [31:0]           irq_in,
   input  logic [NCPU-1:0]       ack_valid,
   input  logic [NCPU*4-1:0]     ack_level,
   output logic [NCPU*4-1:0]     irq_level
);

   localparam int          IDX_W    = 4;
   localparam logic [3:0]  CNT_CODE = 4'(NCPU - 1);

   initial begin
      assert (NCPU >= 1 && NCPU <= 16)
         else $fatal(1, "mpirq_ctrl: NCPU must be 1..16");
      assert (EXT_LINE >= 1 && EXT_LINE < PRIM_N)
         else $fatal(1, "mpirq_ctrl: EXT_LINE must be 1..15");
   end

   logic             aligned;
   logic [IDX_W-1:0] slot;
   logic             wr_hit;
   logic             force_we;
   logic             clear_we;
   word_t            pend;
   word_t            clr_part [NCPU];
   word_t            mask_arr [NCPU];
   logic [EID_W-1:0] eid_arr  [NCPU];
   word_t            ack_clr;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign slot     = bus_addr[5:2];
   assign wr_hit   = bus_sel && bus_wr && aligned;
   assign force_we = wr_hit && (bus_addr == OFS_PEND);
   assign clear_we = wr_hit && (bus_addr == OFS_CLEAR);

   mpirq_pend u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .force_we (force_we),
      .clear_we (clear_we),
      .wdata    (bus_wdata),
      .ack_clr  (ack_clr),
      .pend_o   (pend)
   );

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      logic mask_we;
      assign mask_we = wr_hit && (bus_addr[7:6] == REG_MASK) && (slot == IDX_W'(c));

      mpirq_cpu #(.EXT_LINE(EXT_LINE)) u_cpu (
         .clk       (clk),
         .rst_n     (rst_n),
         .mask_we   (mask_we),
         .wdata     (bus_wdata),
         .pend      (pend),
         .ack_valid (ack_valid[c]),
         .ack_level (ack_level[c*LVL_W +: LVL_W]),
         .level_o   (irq_level[c*LVL_W +: LVL_W]),
         .mask_o    (mask_arr[c]),
         .eid_o     (eid_arr[c]),
         .ack_clr_o (clr_part[c])
      );
   end

   always_comb begin
      ack_clr = '0;
      for (int c = 0; c < NCPU; c++)
         ack_clr = ack_clr | clr_part[c];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && aligned) begin
         if (bus_addr == OFS_PEND)
            bus_rdata = pend;
         else if (bus_addr == OFS_STAT)
            bus_rdata = {CNT_CODE, HAS_BCAST, 27'd0};
         else begin
            for (int c = 0; c < NCPU; c++) begin
               if (slot == IDX_W'(c)) begin
                  if (bus_addr[7:6] == REG_MASK)
                     bus_rdata = mask_arr[c];
                  else if (bus_addr[7:6] == REG_EID)
                     bus_rdata = {27'd0, eid_arr[c]};
               end
            end
         end
      end
   end

   p_ack_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid[0] && ack_level[3:0] != 4'd0 && !irq_in[ack_level[3:0]] && !force_we)
      |=> !pend[$past(ack_level[3:0])]);

   p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel || bus_wr) |-> (bus_rdata == '0));

endmodule

// File: tb/mpirq_ctrl_test.sv
module mpirq_ctrl_test;

   localparam int NCPU = 4;
   localparam int EXT  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [7:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [31:0]       irq_in = '0;
   logic [NCPU-1:0]   ack_valid = '0;
   logic [NCPU*4-1:0] ack_level = '0;
   logic [NCPU*4-1:0] irq_level;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   mpirq_ctrl #(.NCPU(NCPU), .EXT_LINE(EXT), .HAS_BCAST(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .ack_valid(ack_valid), .ack_level(ack_level),
      .irq_level(irq_level)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic ack(input int c, input logic [3:0] l);
      @(negedge clk);
      ack_valid[c] = 1'b1; ack_level[c*4 +: 4] = l;
      @(negedge clk);
      ack_valid = '0; ack_level = '0;
   endtask

   function automatic logic [3:0] lvl(input int c);
      return irq_level[c*4 +: 4];
   endfunction

   function automatic logic [3:0] exp_level(input logic [31:0] p, input logic [31:0] m);
      logic [15:0] v;
      logic [3:0] r;
      v = p[15:0];
      if ((p[31:16] & m[31:16]) != 16'd0) v[EXT] = 1'b1;
      v = v & m[15:0];
      r = 4'd0;
      for (int n = 1; n < 16; n++) if (v[n]) r = 4'(n);
      return r;
   endfunction

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] seed;
      logic [31:0] pat;
      logic [31:0] msk [NCPU];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h04, v); check("R1 pending", v, 32'h0);
      for (int c = 0; c < NCPU; c++) begin
         rd(8'(8'h40 + 4*c), v); check("R1 mask", v, 32'h0);
         rd(8'(8'hC0 + 4*c), v); check("R1 eid", v, 32'h0);
         check("R1 level", 32'(lvl(c)), 32'h0);
      end

      // R10 status
      rd(8'h10, v); check("R10 status", v, 32'(NCPU - 1) << 28);

      // R2 / R3 single-bit sweep over every position
      for (int s = 0; s < 32; s++) begin
         wr(8'h04, 32'h1 << s);
         rd(8'h04, v); check("R2 force bit", v, (s == 0) ? 32'h0 : (32'h1 << s));
         wr(8'h08, 32'h1 << s);
         rd(8'h04, v); check("R3 clear bit", v, 32'h0);
      end

      // R3 partial clear leaves zero-written bits
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h08, 32'h5555_AAAA);
      rd(8'h04, v); check("R3 partial clear", v, 32'hAAAA_5554);
      wr(8'h08, 32'hFFFF_FFFF);

      // R5 / R6 / R7 near-exhaustive sweep
      seed = 32'h1234_5678;
      for (int it = 0; it < 300; it++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         pat  = seed;
         wr(8'h08, 32'hFFFF_FFFF);
         wr(8'h04, pat);
         for (int c = 0; c < NCPU; c++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            msk[c] = (it % 4 == 0) ? (seed & 32'hFFFF_0000) | (32'h1 << EXT) : seed;
            wr(8'(8'h40 + 4*c), msk[c]);
         end
         for (int c = 0; c < NCPU; c++) begin
            check("R6 R7 level", 32'(lvl(c)), 32'(exp_level(pat & 32'hFFFF_FFFE, msk[c])));
            rd(8'(8'h40 + 4*c), v); check("R5 mask readback", v, msk[c]);
         end
      end
      wr(8'h08, 32'hFFFF_FFFF);

      // R4 edge detection
      for (int c = 0; c < NCPU; c++) wr(8'(8'h40 + 4*c), 32'hFFFF_FFFF);
      @(negedge clk); irq_in[5] = 1'b1;
      @(negedge clk);
      check("R4 edge level", 32'(lvl(2)), 32'd5);
      rd(8'h04, v); check("R4 edge sets", v, 32'h20);
      wr(8'h08, 32'h20);
      repeat (2) @(negedge clk);
      rd(8'h04, v); check("R4 steady high no reset", v, 32'h0);
      irq_in[5] = 1'b0;
      @(negedge clk); irq_in[5] = 1'b1;
      @(negedge clk);
      rd(8'h04, v); check("R4 second edge", v, 32'h20);
      irq_in[5] = 1'b0;
      wr(8'h08, 32'hFFFF_FFFF);

      // R8 acknowledge
      wr(8'h04, 32'h0000_0208);
      check("R8 level before ack", 32'(lvl(1)), 32'd9);
      ack(1, 4'd9);
      rd(8'h04, v); check("R8 ack clears", v, 32'h0000_0008);
      check("R8 next level", 32'(lvl(1)), 32'd3);
      @(negedge clk);
      ack_valid[1] = 1'b1; ack_level[7:4] = 4'd3;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h8;
      @(negedge clk);
      ack_valid = '0; ack_level = '0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd(8'h04, v); check("R8 set wins", v, 32'h0000_0008);
      wr(8'h08, 32'hFFFF_FFFF);

      // R7 / R9 extended sources
      wr(8'h40, 32'h0200_0000);
      wr(8'h44, 32'h0);
      wr(8'h48, (32'h1 << EXT) | 32'h0210_0000);
      wr(8'h4C, (32'h1 << EXT) | 32'h0010_0000);
      wr(8'h04, 32'h0210_0000);
      check("R7 carrier needs mask bit", 32'(lvl(0)), 32'd0);
      check("R7 carrier cpu2", 32'(lvl(2)), 32'(EXT));
      check("R7 carrier cpu3", 32'(lvl(3)), 32'(EXT));
      ack(3, 4'(EXT));
      rd(8'hCC, v); check("R9 eid cpu3", v, 32'h14);
      rd(8'h04, v); check("R9 retire 20", v, 32'h0200_0000);
      check("R9 cpu3 idle", 32'(lvl(3)), 32'd0);
      check("R9 cpu2 still", 32'(lvl(2)), 32'(EXT));
      ack(2, 4'(EXT));
      rd(8'hC8, v); check("R9 eid cpu2", v, 32'h19);
      rd(8'hCC, v); check("R9 eid cpu3 kept", v, 32'h14);
      rd(8'h04, v); check("R9 retire 25", v, 32'h0);
      ack(2, 4'(EXT));
      rd(8'hC8, v); check("R9 eid none", v, 32'h0);

      // R11 unused offsets
      wr(8'h04, 32'h0000_0100);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h41, 32'hFFFF_FFFF);
      wr(8'h50, 32'hFFFF_FFFF);
      wr(8'hC8, 32'hFFFF_FFFF);
      rd(8'h04, v); check("R11 writes ignored pend", v, 32'h0000_0100);
      rd(8'h40, v); check("R11 writes ignored mask", v, 32'h0200_0000);
      rd(8'hC8, v); check("R11 eid not writable", v, 32'h0);
      rd(8'h00, v); check("R11 read 0x00", v, 32'h0);
      rd(8'h08, v); check("R11 read 0x08", v, 32'h0);
      rd(8'h0C, v); check("R11 read 0x0C", v, 32'h0);
      rd(8'h14, v); check("R11 read 0x14", v, 32'h0);
      rd(8'h41, v); check("R11 unaligned", v, 32'h0);
      rd(8'h50, v); check("R11 mask slot beyond", v, 32'h0);
      rd(8'hD0, v); check("R11 eid slot beyond", v, 32'h0);
      rd(8'h80, v); check("R11 read 0x80", v, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule